// File: doc/BRIEF.md
# External interrupt capture unit

This block takes up to eight active-low interrupt lines from outside the chip and turns them into per-source request bits for a downstream priority stage. Each line passes through a two-flop synchroniser. Software then chooses, source by source, whether the line is sensed as a low level or as a high-to-low transition.

Edge events are latched in a pending register. Software clears an event by writing a one to its bit. A mask register decides which pending sources drive their request output. Clearing a mask bit hides the request but keeps the pending state.

Software reaches three registers through a plain 32-bit port. The port has a write strobe, a read strobe and a two-bit register select. Read data returns one cycle after the read strobe, together with a valid flag.

Top module: `ext_irq_capture`

## Requirements
- R1: After reset the mask register, the sense register and the pending register all read zero, and every request output is low.
- R2: In level mode a source's pending bit reads 1 exactly while its synchronised input is low. A change on the pin appears in a read issued two cycles after the change, and not in a read issued one cycle after it.
- R3: In level mode, writing 1 to the pending bit while the input is still low leaves the bit reading 1.
- R4: In edge mode a falling edge on the pin sets the pending bit. The bit shows in a read issued three cycles after the pin falls and not earlier, and it stays set after the pin returns high.
- R5: Writing 1 to an edge-mode pending bit clears it. Writing 0 leaves it unchanged.
- R6: A falling edge that is detected in the same cycle as a clearing write wins, and the pending bit stays set.
- R7: Request output k is high only while pending bit k and mask bit k are both 1. Clearing mask bit k drops the request and keeps the pending bit.
- R8: Register select values are 0 for pending, 1 for mask, 2 for sense and 3 for an unused slot that reads zero. In the pending and mask registers, source k uses bit 31-k. In the sense register, source n uses bit 15-n, where 1 selects edge mode and 0 selects level mode. All other bits read zero.
- R9: In edge mode a rising edge on the pin does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | NSRC | Active-low external interrupt lines, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 sense, 3 reads zero |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| req | output | NSRC | Masked request per source |

## Verification
The assertions check the edge-mode pending bit on every cycle. A detected fall sets it, and a clearing write with no fall empties it. Without a clear or a fall the bit holds. A level-mode source whose first synchroniser stage is low must read pending on the next cycle. Withdrawing a mask bit must keep the pending state while dropping the request.

Some behaviours can only be shown by the bench's scenarios. These are the exact read latency after a pin change and the bit placement in each register. The bench also shows a rising edge that sets nothing, a clear that collides with a fresh edge, and several sources pending at once in mixed modes.

// File: rtl/ext_irq_capture.sv
module ext_irq_capture #(
  parameter int NSRC = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            reg_rvalid,
  output logic [NSRC-1:0] req
);
  localparam int SENSE_TOP = 15;
  localparam logic [1:0] A_PEND  = 2'd0;
  localparam logic [1:0] A_MASK  = 2'd1;
  localparam logic [1:0] A_SENSE = 2'd2;

  logic [NSRC-1:0] sy1, sy2, sy3;
  logic [NSRC-1:0] edge_mode, mask_q, pend_q;
  logic [NSRC-1:0] clr, fall, pend_vis;
  logic [DW-1:0]   pend_word, mask_word, sense_word;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata;

  wire wr_pend  = reg_wr && reg_addr == A_PEND;
  wire wr_mask  = reg_wr && reg_addr == A_MASK;
  wire wr_sense = reg_wr && reg_addr == A_SENSE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
      sy3 <= '1;
    end else begin
      sy1 <= irq_n;
      sy2 <= sy1;
      sy3 <= sy2;
    end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign clr[i]      = wr_pend && reg_wdata[DW-1-i];
    assign fall[i]     = sy3[i] & ~sy2[i];
    assign pend_vis[i] = edge_mode[i] ? pend_q[i] : ~sy2[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= edge_mode[i] & (fall[i] | (pend_q[i] & ~clr[i]));

    assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode[i] && fall[i] |=> pend_q[i]);
    assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode[i] && pend_q[i] && !clr[i] |=> pend_q[i]);
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode[i] && clr[i] && !fall[i] |=> !pend_q[i]);
    assert_level_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode[i] && !wr_sense && !sy1[i] |=> pend_vis[i]);
    assert_mask_keeps_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode[i] && pend_q[i] && !clr[i] && wr_mask && !reg_wdata[DW-1-i]
      |=> pend_q[i] && !req[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_mode <= '0;
      mask_q    <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (wr_sense) edge_mode[i] <= reg_wdata[SENSE_TOP-i];
        if (wr_mask)  mask_q[i]    <= reg_wdata[DW-1-i];
      end
    end

  assign req = pend_vis & mask_q;

  always_comb begin
    pend_word  = '0;
    mask_word  = '0;
    sense_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      pend_word[DW-1-i]     = pend_vis[i];
      mask_word[DW-1-i]     = mask_q[i];
      sense_word[SENSE_TOP-i] = edge_mode[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd)
        case (reg_addr)
          A_PEND:  reg_rdata <= pend_word;
          A_MASK:  reg_rdata <= mask_word;
          A_SENSE: reg_rdata <= sense_word;
          default: reg_rdata <= '0;
        endcase
    end
endmodule

// File: tb/sim_ext_irq_capture.sv
module sim_ext_irq_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_n = 8'hFF;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [7:0]  req;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  ext_irq_capture u0 (.clk, .rst_n, .irq_n, .reg_wr, .reg_rd, .reg_addr,
                      .reg_wdata, .reg_rdata, .reg_rvalid, .req);

  always #4 clk = ~clk;

  function automatic logic [31:0] pb(int k); return 32'h1 << (31 - k); endfunction
  function automatic logic [31:0] sb(int n); return 32'h1 << (15 - n); endfunction

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic drv(int k, logic v); @(negedge clk); irq_n[k] = v; endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] e, string t);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic chk_req(logic [7:0] e, string t);
    @(negedge clk);
    n_cmp++;
    if (req !== e) begin
      n_bad++;
      $display("FAIL %s req actual %h expected %h", t, req, e);
    end
  endtask

  always @(negedge clk)
    if (rst_n && reg_rvalid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s actual %h expected %h", t, reg_rdata, e);
        end
      end
    end

  initial begin
    #(8 * 50000);
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state, R8 unused slot
    rd(2'd0, 32'h0, "R1 pending");
    rd(2'd1, 32'h0, "R1 mask");
    rd(2'd2, 32'h0, "R1 sense");
    rd(2'd3, 32'h0, "R8 unused slot");
    chk_req(8'h00, "R1 req");

    // R2 level latency on source 2
    drv(2, 1'b0);
    rd(2'd0, 32'h0, "R2 one cycle");
    rd(2'd0, pb(2), "R2 two cycles");

    // R3 clear ignored while low
    wr(2'd0, pb(2));
    rd(2'd0, pb(2), "R3 level w1c");

    // R7 and R8 mask placement
    wr(2'd1, pb(2) | pb(5));
    chk_req(8'h04, "R7 masked request");
    rd(2'd1, pb(2) | pb(5), "R8 mask bits");

    drv(2, 1'b1);
    idle(3);
    rd(2'd0, 32'h0, "R2 release");
    chk_req(8'h00, "R2 req release");

    // R4 edge mode on source 5, sense layout R8
    wr(2'd2, sb(5) | sb(0));
    rd(2'd2, 32'h0000_8400, "R8 sense bits");
    wr(2'd2, sb(5));
    drv(5, 1'b0);
    rd(2'd0, 32'h0, "R4 one cycle");
    rd(2'd0, 32'h0, "R4 two cycles");
    rd(2'd0, pb(5), "R4 three cycles");
    drv(5, 1'b1);
    idle(3);
    rd(2'd0, pb(5), "R4 held after release");
    chk_req(8'h20, "R7 edge request");

    // R5 write zero keeps, write one clears
    wr(2'd0, 32'h0);
    rd(2'd0, pb(5), "R5 write zero");
    wr(2'd0, pb(5));
    rd(2'd0, 32'h0, "R5 write one");
    chk_req(8'h00, "R5 req cleared");

    // R9 rising edge sets nothing
    drv(5, 1'b0);
    idle(3);
    wr(2'd0, pb(5));
    rd(2'd0, 32'h0, "R5 clear while low");
    drv(5, 1'b1);
    idle(3);
    rd(2'd0, 32'h0, "R9 rising edge");

    // R6 edge coincident with clear
    drv(5, 1'b0);
    idle(3);
    rd(2'd0, pb(5), "R4 second edge");
    drv(5, 1'b1);
    idle(3);
    drv(5, 1'b0);
    idle(1);
    wr(2'd0, pb(5));
    rd(2'd0, pb(5), "R6 edge beats clear");

    // R7 mask removal keeps pending
    chk_req(8'h20, "R7 before unmask");
    wr(2'd1, pb(2));
    chk_req(8'h00, "R7 masked off");
    rd(2'd0, pb(5), "R7 pending kept");
    wr(2'd1, pb(5));
    chk_req(8'h20, "R7 restored");

    // mixed modes: source 0 edge, source 7 level
    wr(2'd2, sb(5) | sb(0));
    drv(0, 1'b0);
    drv(7, 1'b0);
    idle(4);
    rd(2'd0, pb(0) | pb(5) | pb(7), "R8 multi pending");
    rd(2'd2, 32'h0000_8400, "R8 sense readback");
    wr(2'd1, 32'hFF00_0000);
    chk_req(8'hA1, "R7 multi request");

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule